// File: doc/BRIEF.md
# Banked GPIO Port with Selectable Drive Modes

This block is a register-mapped general-purpose I/O port of up to 24 pins. The pins are grouped into banks of eight. Pin `i` belongs to bank `i / 8` at bit position `i % 8`. A simple synchronous byte-wide bus controls it. Software sets the direction of each pin and updates output data through a staged data-and-mask pair, so that only selected bits change. Software also reads back the live pin levels. Each output pin can drive push-pull, open-drain (drives low, otherwise floats) or open-source (drives high, otherwise floats).

For every pin the port presents an output value and an output enable. The pad turns these into a tri-state driver. A port-level hold bit keeps the whole port quiet until software clears it. The hold bit is set after reset. While it is set, every configuration register is forced to zero and every output enable is low.

Register map (byte addresses):

| Address | Contents |
|---|---|
| `0x00 + 2b` | data staging for bank `b`; reads return pin levels |
| `0x01 + 2b` | write mask for bank `b` |
| `0x08 + b` | direction of bank `b` |
| `0x10 + 2b` | drive-mode select of bank `b` |
| `0x11 + 2b` | drive-mode enable of bank `b` |
| `0x20` | port hold, bit 0 |

Top module: `gpio_bank_port`

## Requirements
- R1: Reset gives the following state. The hold register at address 0x20 reads 1. All mask, direction, mode-select and mode-enable registers read 0. Every output enable `pin_oe` is 0.
- R2: While the hold bit is 1, the port behaves as follows. Bus writes to any address other than 0x20 have no effect. All configuration registers read 0. All `pin_oe` bits are 0. Writing 0 to bit 0 of 0x20 releases the port. Writing 1 there again clears every configuration register.
- R3: A write to the data address `0x00+2b` only stages a byte, and the outputs stay unchanged. A later write of mask `m` to `0x01+2b` commits the change. Each bank-`b` output-data bit whose mask bit is 1 takes the staged value. Each bit whose mask bit is 0 keeps its value. Pin `8b+k` maps to bit `k` of bank `b`.
- R4: A direction bit of 1 (at `0x08+b`) makes the pin an output. A direction bit of 0 makes it an input. An input pin never asserts `pin_oe`, whatever its data or drive-mode settings.
- R5: When an output pin's enable bit (at `0x11+2b`) is 0, the pin is push-pull. Its `pin_oe` is 1 and its `pin_out` equals its data bit.
- R6: When the enable bit is 1 and the select bit (at `0x10+2b`) is 0, the pin is open-drain. Its `pin_oe` is 1 only when its data bit is 0, and it then drives `pin_out` = 0.
- R7: When the enable bit is 1 and the select bit is 1, the pin is open-source. Its `pin_oe` is 1 only when its data bit is 1, and it then drives `pin_out` = 1.
- R8: Reads are registered. `bus_rdata` shows the addressed register one clock after `bus_addr` is sampled. A read of `0x00+2b` returns `pin_in` bits `8b+7..8b`. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Sampled pin levels |
| pin_out | output | 24 | Per-pin output value |
| pin_oe | output | 24 | Per-pin output enable |

## Verification
The assertions assume the following about the inputs:
- `bus_addr`, `bus_we` and `bus_wdata` are stable around the rising clock edge.
- A mask write is judged against the data staged before it.
- `pin_in` is steady for the cycle in which a data address is read.

The bench respects these assumptions in three ways. It changes every input on the falling edge. It writes only the mapped addresses plus a few unmapped ones. It holds `pin_in` constant across each read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned BUS_W     = 8;
  localparam int unsigned DATA_BASE = 0;
  localparam int unsigned DIR_BASE  = 8;
  localparam int unsigned DRV_BASE  = 16;
  localparam int unsigned HOLD_ADDR = 32;

  typedef enum logic [1:0] {
    DRV_PUSH_PULL   = 2'd0,
    DRV_OPEN_DRAIN  = 2'd1,
    DRV_OPEN_SOURCE = 2'd2
  } drive_e;
endpackage

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_port_pkg::*;
#(
  parameter int W      = 8,
  parameter int IDX    = 0,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      sel_q,
  output logic [W-1:0]      ena_q
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_BASE + 2 * IDX);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(DATA_BASE + 2 * IDX + 1);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_BASE + IDX);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(DRV_BASE + 2 * IDX);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(DRV_BASE + 2 * IDX + 1);

  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] data_d, mask_d, dir_d, sel_d, ena_d;
  logic         upd;

  assign upd = hold | wr_en;

  always_comb begin
    stage_d = stage_q;
    data_d  = data_q;
    mask_d  = mask_q;
    dir_d   = dir_q;
    sel_d   = sel_q;
    ena_d   = ena_q;
    if (hold) begin
      stage_d = '0;
      data_d  = '0;
      mask_d  = '0;
      dir_d   = '0;
      sel_d   = '0;
      ena_d   = '0;
    end else if (wr_en) begin
      if (wr_addr == A_DATA) stage_d = wr_data;
      if (wr_addr == A_MASK) begin
        mask_d = wr_data;
        data_d = (data_q & ~wr_data) | (stage_q & wr_data);
      end
      if (wr_addr == A_DIR) dir_d = wr_data;
      if (wr_addr == A_SEL) sel_d = wr_data;
      if (wr_addr == A_ENA) ena_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      data_q  <= '0;
      mask_q  <= '0;
      dir_q   <= '0;
      sel_q   <= '0;
      ena_q   <= '0;
    end else if (upd) begin
      stage_q <= stage_d;
      data_q  <= data_d;
      mask_q  <= mask_d;
      dir_q   <= dir_d;
      sel_q   <= sel_d;
      ena_q   <= ena_d;
    end
  end

  assert_hold_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (data_q == '0 && mask_q == '0 && dir_q == '0 && sel_q == '0 && ena_q == '0));

  assert_stage_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && wr_en && wr_addr == A_DATA) |=> $stable(data_q));

  assert_mask_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && wr_en && wr_addr == A_MASK) |=> (((data_q ^ $past(data_q)) & ~$past(wr_data)) == '0));
endmodule

// File: rtl/gpio_drive_resolve.sv
module gpio_drive_resolve
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] ena,
  output logic [W-1:0] out,
  output logic [W-1:0] oe
);
  for (genvar k = 0; k < W; k++) begin : g_pin
    drive_e mode;
    always_comb begin
      if (!ena[k])     mode = DRV_PUSH_PULL;
      else if (sel[k]) mode = DRV_OPEN_SOURCE;
      else             mode = DRV_OPEN_DRAIN;
    end
    always_comb begin
      unique case (mode)
        DRV_OPEN_DRAIN: begin
          out[k] = 1'b0;
          oe[k]  = dir[k] & ~data[k];
        end
        DRV_OPEN_SOURCE: begin
          out[k] = 1'b1;
          oe[k]  = dir[k] & data[k];
        end
        default: begin
          out[k] = data[k];
          oe[k]  = dir[k];
        end
      endcase
    end
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int NB     = 3,
  parameter int W      = 8,
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   hold,
  input  logic [NB-1:0][W-1:0]   lvl,
  input  logic [NB-1:0][W-1:0]   mask,
  input  logic [NB-1:0][W-1:0]   dir,
  input  logic [NB-1:0][W-1:0]   sel,
  input  logic [NB-1:0][W-1:0]   ena,
  output logic [W-1:0]           rdata
);
  localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(HOLD_ADDR);

  always_comb begin
    rdata = '0;
    if (addr == A_HOLD) rdata = W'(hold);
    for (int b = 0; b < NB; b++) begin
      if (addr == ADDR_W'(DATA_BASE + 2 * b))     rdata = lvl[b];
      if (addr == ADDR_W'(DATA_BASE + 2 * b + 1)) rdata = mask[b];
      if (addr == ADDR_W'(DIR_BASE + b))          rdata = dir[b];
      if (addr == ADDR_W'(DRV_BASE + 2 * b))      rdata = sel[b];
      if (addr == ADDR_W'(DRV_BASE + 2 * b + 1))  rdata = ena[b];
    end
  end
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int ADDR_W    = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [BANK_W-1:0]             bus_wdata,
  output logic [BANK_W-1:0]             bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   pin_in,
  output logic [NUM_BANKS*BANK_W-1:0]   pin_out,
  output logic [NUM_BANKS*BANK_W-1:0]   pin_oe
);
  localparam int NPINS = NUM_BANKS * BANK_W;
  localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(HOLD_ADDR);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic hold_q, hold_d, hold_upd;
  assign hold_upd = bus_we && (bus_addr == A_HOLD);
  assign hold_d   = bus_wdata[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   hold_q <= 1'b1;
    else if (hold_upd) hold_q <= hold_d;
  end

  logic [NUM_BANKS-1:0][BANK_W-1:0] data_a, mask_a, dir_a, sel_a, ena_a, out_a, oe_a, lvl_a;
  logic [NPINS-1:0] oe_raw, dir_all, sel_all, ena_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_port_bank #(.W(BANK_W), .IDX(b), .ADDR_W(ADDR_W)) bank_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .hold    (hold_q),
      .wr_en   (bus_we),
      .wr_addr (bus_addr),
      .wr_data (bus_wdata),
      .data_q  (data_a[b]),
      .mask_q  (mask_a[b]),
      .dir_q   (dir_a[b]),
      .sel_q   (sel_a[b]),
      .ena_q   (ena_a[b])
    );
    gpio_drive_resolve #(.W(BANK_W)) drv_i (
      .data (data_a[b]),
      .dir  (dir_a[b]),
      .sel  (sel_a[b]),
      .ena  (ena_a[b]),
      .out  (out_a[b]),
      .oe   (oe_a[b])
    );
    assign lvl_a[b] = pin_in[b*BANK_W +: BANK_W];
  end

  assign pin_out = out_a;
  assign oe_raw  = oe_a;
  assign dir_all = dir_a;
  assign sel_all = sel_a;
  assign ena_all = ena_a;
  assign pin_oe  = hold_q ? '0 : oe_raw;

  logic [BANK_W-1:0] rdata_d;

  gpio_read_mux #(.NB(NUM_BANKS), .W(BANK_W), .ADDR_W(ADDR_W)) rmux_i (
    .addr  (bus_addr),
    .hold  (hold_q),
    .lvl   (lvl_a),
    .mask  (mask_a),
    .dir   (dir_a),
    .sel   (sel_a),
    .ena   (ena_a),
    .rdata (rdata_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else             bus_rdata <= rdata_d;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_q |-> (pin_oe == '0));

  assert_input_no_oe_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_oe & ~dir_all) == '0);

  assert_drain_low_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_oe & ena_all & ~sel_all & pin_out) == '0);

  assert_source_high_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_oe & ena_all & sel_all & ~pin_out) == '0);

  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == ADDR_W'(DATA_BASE)) |=> (bus_rdata == $past(pin_in[BANK_W-1:0])));
endmodule

// File: tb/gpio_bank_port_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_port_tb_top;
  localparam int NB = 3;
  localparam int W  = 8;
  localparam int NP = NB * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [5:0]    bus_addr;
  logic          bus_we;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;

  always #4 clk = ~clk;

  gpio_bank_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0] m_data [NB];
  logic [7:0] m_stage[NB];
  logic [7:0] m_mask [NB];
  logic [7:0] m_dir  [NB];
  logic [7:0] m_sel  [NB];
  logic [7:0] m_ena  [NB];
  logic       m_hold;

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin
      m_data[b] = 0; m_stage[b] = 0; m_mask[b] = 0;
      m_dir[b] = 0; m_sel[b] = 0; m_ena[b] = 0;
    end
  endtask

  task automatic model_write(input logic [5:0] a, input logic [7:0] d);
    if (a == 6'h20) begin
      m_hold = d[0];
      if (d[0]) model_clear();
      return;
    end
    if (m_hold) return;
    for (int b = 0; b < NB; b++) begin
      if (a == 6'(2*b))       m_stage[b] = d;
      if (a == 6'(2*b+1)) begin m_mask[b] = d; m_data[b] = (m_data[b] & ~d) | (m_stage[b] & d); end
      if (a == 6'(8+b))       m_dir[b] = d;
      if (a == 6'(16+2*b))    m_sel[b] = d;
      if (a == 6'(17+2*b))    m_ena[b] = d;
    end
  endtask

  function automatic logic [7:0] model_read(input logic [5:0] a, input logic [NP-1:0] lv);
    logic [7:0] r = 0;
    if (a == 6'h20) r = {7'b0, m_hold};
    for (int b = 0; b < NB; b++) begin
      if (a == 6'(2*b))    r = lv[b*8 +: 8];
      if (a == 6'(2*b+1))  r = m_mask[b];
      if (a == 6'(8+b))    r = m_dir[b];
      if (a == 6'(16+2*b)) r = m_sel[b];
      if (a == 6'(17+2*b)) r = m_ena[b];
    end
    return r;
  endfunction

  // Expected out (meaningful only where oe is 1) and oe, per R4..R7
  task automatic model_pins(output logic [NP-1:0] eo, output logic [NP-1:0] eoe);
    eo = 0; eoe = 0;
    for (int i = 0; i < NP; i++) begin
      int b = i / 8;
      int k = i % 8;
      logic d = m_data[b][k];
      if (m_hold || !m_dir[b][k]) eoe[i] = 0;
      else if (!m_ena[b][k]) begin eoe[i] = 1; eo[i] = d; end
      else if (!m_sel[b][k]) begin eoe[i] = !d; eo[i] = 0; end
      else begin eoe[i] = d; eo[i] = 1; end
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pins(input string req);
    logic [NP-1:0] eo, eoe;
    model_pins(eo, eoe);
    check({req, " oe"}, 32'(pin_oe), 32'(eoe));
    check({req, " out"}, 32'(pin_out & eoe), 32'(eo & eoe));
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    model_write(a, d);
  endtask

  task automatic rd_check(input string req, input logic [5:0] a);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    check(req, 32'(bus_rdata), 32'(model_read(a, pin_in)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd4242;
    void'($urandom(seed));
    rst_n = 0; bus_addr = 0; bus_we = 0; bus_wdata = 0; pin_in = 24'h5A3C96;
    m_hold = 1; model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_check("R1 hold reads 1", 6'h20);
    rd_check("R1 dir bank1", 6'h09);
    rd_check("R1 ena bank2", 6'h15);
    check("R1 oe zero", 32'(pin_oe), 32'h0);

    // R2 writes ignored during hold
    wr(6'h08, 8'hFF);
    wr(6'h00, 8'hFF); wr(6'h01, 8'hFF);
    rd_check("R2 dir ignored", 6'h08);
    rd_check("R2 mask ignored", 6'h01);
    check_pins("R2 quiet");

    wr(6'h20, 8'h00);
    rd_check("R2 hold released", 6'h20);

    // R3 stage then commit, bank 1
    wr(6'h09, 8'hFF);
    wr(6'h02, 8'hA5);
    check_pins("R3 stage only");
    wr(6'h03, 8'h0F);
    check_pins("R3 mask commit");
    check("R3 bank1 bits", 32'(pin_out[15:8] & pin_oe[15:8]), 32'h05);
    wr(6'h02, 8'hFF);
    wr(6'h03, 8'hF0);
    check("R3 upper nibble", 32'(pin_out[15:8]), 32'hF5);

    // R4 input never drives
    wr(6'h09, 8'h00);
    wr(6'h13, 8'hFF);
    check_pins("R4 input quiet");
    check("R4 bank1 oe", 32'(pin_oe[15:8]), 32'h0);

    // R5/R6/R7 on bank 0
    wr(6'h08, 8'hFF);
    wr(6'h00, 8'h33); wr(6'h01, 8'hFF);
    check_pins("R5 push-pull");
    wr(6'h11, 8'hFF); wr(6'h10, 8'h00);
    check_pins("R6 open-drain");
    check("R6 oe bank0", 32'(pin_oe[7:0]), 32'hCC);
    wr(6'h10, 8'hFF);
    check_pins("R7 open-source");
    check("R7 oe bank0", 32'(pin_oe[7:0]), 32'h33);

    // R8 readback
    pin_in = 24'hC3_81_7E;
    rd_check("R8 bank0 level", 6'h00);
    rd_check("R8 bank2 level", 6'h04);
    rd_check("R8 unmapped", 6'h3F);

    // R2 re-entering hold clears
    wr(6'h20, 8'h01);
    check_pins("R2 re-hold quiet");
    rd_check("R2 sel cleared", 6'h10);
    wr(6'h20, 8'h00);
    rd_check("R2 dir cleared", 6'h08);

    // Random phase
    for (int n = 0; n < 400; n++) begin
      int unsigned r = $urandom_range(0, 99);
      logic [5:0] a;
      int unsigned pick = $urandom_range(0, 15);
      if (pick < 6)       a = 6'(pick);
      else if (pick < 9)  a = 6'(8 + pick - 6);
      else if (pick < 15) a = 6'(16 + pick - 9);
      else                a = (r < 3) ? 6'h20 : 6'h3A;
      if (r < 70) begin
        logic [7:0] d = 8'($urandom);
        if (a == 6'h20) d = {7'b0, d[0] & (r < 1)};
        wr(a, d);
        check_pins("R3 R5 R6 R7 random");
      end else begin
        pin_in = 24'($urandom);
        rd_check("R8 random read", a);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule